// File: doc/BRIEF.md
# Memory Byte Bit Operator

This block performs a single-bit operation on one byte held in external memory. A command carries a base address, a signed 16-bit displacement, a 3-bit bit index and a two-bit operation selector. The unit forms the byte address, issues one read, waits for the read data for as many cycles as memory takes, and records the original value of the selected bit as a zero flag. For the modifying operations it then issues one write of the changed byte.

While a command is in progress the unit holds `busy` high and ignores any new command. When it finishes it pulses `done` for one cycle and presents the zero-flag result. The surrounding core updates only its zero flag from `zf_out` when `zf_we` is high. Memory sees one request at a time on a simple request and valid port, so every read-modify-write is atomic from the unit's point of view.

Top module: `bitop_unit`

## Requirements
- R1: After reset `busy`, `done`, `mem_req` and `zf_we` are 0.
- R2: The byte address equals `base_addr` plus `disp` sign-extended to the address width, modulo 2^AW. It is the same on the read and on the write of a command.
- R3: Each command issues exactly one read request (`mem_req`=1, `mem_we`=0). The request is held until `rd_valid` is seen, and the unit waits any number of cycles for it.
- R4: `zf_out` is 1 when the selected bit of the byte read was 0, and 0 when it was 1. `zf_we` pulses together with `done`.
- R5: Op code 0 (set) writes the byte with the selected bit forced to 1.
- R6: Op code 1 (toggle) writes the byte with the selected bit inverted.
- R7: Op code 2 (clear) writes the byte with the selected bit forced to 0.
- R8: Op code 3 (test) issues no write, so memory is unchanged.
- R9: In every write, all bits other than the selected one equal the byte that was read.
- R10: `cmd_valid` is ignored while `busy` is high.
- R11: `done` is a one-cycle pulse after the last memory access. `busy` is high from the cycle after acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 2 | 0 set, 1 toggle, 2 clear, 3 test |
| base_addr | input | AW | Base register value |
| disp | input | 16 | Signed displacement |
| bit_sel | input | 3 | Bit index in the byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| zf_we | output | 1 | Zero flag update strobe |
| zf_out | output | 1 | New zero flag value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| rd_valid | input | 1 | Read data valid / write accepted |
| rd_data | input | 8 | Read byte |

## Verification
The bench sweeps every op code against every bit index, using byte patterns in which the target bit is both 0 and 1. A mask built from the wrong bit, or a set and clear that are swapped, would corrupt neighbouring bits or invert the flag. Displacements at the sign boundary (0x7FFF, 0x8000, 0xFFFF) catch a unit that zero-extends. Read latencies of zero to several cycles catch a unit that samples data early. The bench fires extra commands while the unit is busy; a design that takes them would issue a second access or change its address partway through. Test operations must leave the backing memory untouched.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_TGL = 2'd1,
        OP_CLR = 2'd2,
        OP_TST = 2'd3
    } bitop_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RREQ  = 3'd1,
        ST_CALC  = 3'd2,
        ST_WREQ  = 3'd3,
        ST_DONE  = 3'd4
    } bitop_st_e;
endpackage

// File: rtl/bitop_addr.sv
module bitop_addr #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - DW;
    logic [AW-1:0] disp_ext;
    generate
        if (EXT > 0) begin : g_ext
            assign disp_ext = {{EXT{disp[DW-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[AW-1:0];
        end
    endgenerate
    assign addr = base + disp_ext;
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int BW = 8,
    localparam int IW = $clog2(BW)
) (
    input  bitop_e          op,
    input  logic [IW-1:0]   idx,
    input  logic [BW-1:0]   din,
    output logic [BW-1:0]   dout,
    output logic            zf
);
    logic [BW-1:0] mask;
    always_comb begin
        mask = '0;
        mask[idx] = 1'b1;
        zf = ~din[idx];
        unique case (op)
            OP_SET:  dout = din | mask;
            OP_TGL:  dout = din ^ mask;
            OP_CLR:  dout = din & ~mask;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int AW = 32,
    parameter int DISPW = 16,
    parameter int BW = 8,
    localparam int IW = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] base_addr,
    input  logic [DISPW-1:0] disp,
    input  logic [IW-1:0] bit_sel,
    output logic          busy,
    output logic          done,
    output logic          zf_we,
    output logic          zf_out,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] mem_wdata,
    input  logic          rd_valid,
    input  logic [BW-1:0] rd_data
);
    typedef struct packed {
        bitop_st_e      st;
        bitop_e         op;
        logic [IW-1:0]  idx;
        logic [AW-1:0]  addr;
        logic [BW-1:0]  rbyte;
        logic [BW-1:0]  wbyte;
        logic           zf;
    } state_t;

    state_t s_d, s_q;
    logic [AW-1:0] ea;
    logic [BW-1:0] alu_out;
    logic          alu_zf;

    bitop_addr #(.AW(AW), .DW(DISPW)) addr_i (
        .base(base_addr), .disp(disp), .addr(ea)
    );

    bitop_alu #(.BW(BW)) alu_i (
        .op(s_q.op), .idx(s_q.idx), .din(s_q.rbyte),
        .dout(alu_out), .zf(alu_zf)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (cmd_valid) begin
                s_d.st   = ST_RREQ;
                s_d.op   = bitop_e'(cmd_op);
                s_d.idx  = bit_sel;
                s_d.addr = ea;
            end
            ST_RREQ: if (rd_valid) begin
                s_d.rbyte = rd_data;
                s_d.st    = ST_CALC;
            end
            ST_CALC: begin
                s_d.zf    = alu_zf;
                s_d.wbyte = alu_out;
                s_d.st    = (s_q.op == OP_TST) ? ST_DONE : ST_WREQ;
            end
            ST_WREQ: if (rd_valid) s_d.st = ST_DONE;
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: OP_TST, idx: '0, addr: '0,
                     rbyte: '0, wbyte: '0, zf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = (s_q.st == ST_DONE);
    assign zf_we     = done;
    assign zf_out    = s_q.zf;
    assign mem_req   = (s_q.st == ST_RREQ) || (s_q.st == ST_WREQ);
    assign mem_we    = (s_q.st == ST_WREQ);
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.wbyte;

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !mem_req) // R1
        else $error("reset state");
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mem_addr)) // R2
        else $error("address moved");
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !rd_valid |=> mem_req && $stable(mem_we)) // R3
        else $error("request dropped");
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> s_q.op != OP_TST) // R8
        else $error("test wrote");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy) // R11
        else $error("done pulse");
    AST_ZF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        zf_we |-> done) // R4
        else $error("zf strobe");
    AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $countones(mem_wdata ^ s_q.rbyte) <= 1) // R9
        else $error("extra bits changed");
endmodule

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;
    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic        cmd_valid = 0;
    logic [1:0]  cmd_op = 0;
    logic [31:0] base_addr = 0;
    logic [15:0] disp = 0;
    logic [2:0]  bit_sel = 0;
    logic busy, done, zf_we, zf_out, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, rd_data;
    logic        rd_valid;

    bitop_unit dut_i (.*);

    int tests = 0, fails = 0;
    int latency = 0, wait_cnt = 0;
    logic [7:0] mem [0:255];
    int reads = 0, writes = 0;
    logic [31:0] wr_addr_seen, rd_addr_seen;

    // behavioural memory: responds after `latency` cycles of request
    always_comb begin
        rd_valid = mem_req && (wait_cnt >= latency);
        rd_data  = mem[mem_addr[7:0]];
    end
    always_ff @(posedge clk) begin
        if (mem_req && !rd_valid) wait_cnt <= wait_cnt + 1;
        else wait_cnt <= 0;
        if (rd_valid) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                writes <= writes + 1; wr_addr_seen <= mem_addr;
            end else begin
                reads <= reads + 1; rd_addr_seen <= mem_addr;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [31:0] base, input logic [15:0] d,
                       input logic [2:0] b, input logic [7:0] init, input int lat, input bit spam);
        logic [31:0] ea;
        logic [7:0] exp_b;
        logic zf_seen, zf_val;
        int cyc;
        ea = base + {{16{d[15]}}, d};
        mem[ea[7:0]] = init;
        latency = lat;
        reads = 0; writes = 0;
        @(negedge clk);
        cmd_op = op; base_addr = base; disp = d; bit_sel = b; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = spam;
        base_addr = base + 32'h10; cmd_op = 2'd0; bit_sel = b + 3'd1;
        zf_seen = 0; zf_val = 0; cyc = 0;
        while (!done && cyc < 100) begin
            if (!busy) begin
                fails++;
                $display("FAIL R11 busy low before done act=0 exp=1");
            end
            @(negedge clk); cyc++;
        end
        check("R4 zf_we with done", {31'd0, zf_we}, 32'd1);
        zf_val = zf_out;
        @(negedge clk);
        cmd_valid = 0;
        check("R11 done one cycle", {31'd0, done}, 32'd0);
        case (op)
            2'd0: exp_b = init | (8'd1 << b);
            2'd1: exp_b = init ^ (8'd1 << b);
            2'd2: exp_b = init & ~(8'd1 << b);
            default: exp_b = init;
        endcase
        check("R4 zf value", {31'd0, zf_val}, {31'd0, ~init[b]});
        check("R3 one read", reads, 1);
        check("R2 read addr", rd_addr_seen, ea);
        if (op == 2'd3) begin
            check("R8 no write", writes, 0);
            check("R8 memory unchanged", {24'd0, mem[ea[7:0]]}, {24'd0, init});
        end else begin
            check("R5 R6 R7 one write", writes, 1);
            check("R2 write addr", wr_addr_seen, ea);
            check("R9 written byte", {24'd0, mem[ea[7:0]]}, {24'd0, exp_b});
        end
        if (spam) check("R10 spam ignored", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        #1;
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 req", {31'd0, mem_req}, 0);
        check("R1 done", {31'd0, done}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        // sweep all ops, bits, two patterns (bit 0 and 1)
        for (int op = 0; op < 4; op++)
            for (int b = 0; b < 8; b++) begin
                run(op[1:0], 32'h100 + b, 16'h0004, b[2:0], 8'hA5 ^ (8'd1 << b), b % 3, 0);
                run(op[1:0], 32'h100 + b, 16'h0004, b[2:0], 8'h5A | (8'd1 << b), 3, 1);
                run(op[1:0], 32'h100 + b, 16'h0004, b[2:0], 8'hFF & ~(8'd1 << b), 0, 1);
            end
        // displacement sign boundaries
        run(2'd1, 32'h0001_0000, 16'hFFFF, 3'd7, 8'h80, 2, 0); // R2 -1
        run(2'd0, 32'h0001_0000, 16'h8000, 3'd2, 8'h00, 1, 1); // R2 -32768
        run(2'd2, 32'h0000_0010, 16'h7FFF, 3'd4, 8'hFF, 4, 0); // R2 +32767
        run(2'd3, 32'hFFFF_FFF0, 16'h0020, 3'd0, 8'h01, 5, 1); // R2 wrap
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule